// File: doc/BRIEF.md
# Stateful Transition-Limiting Bus Inversion Codec

This block encodes a wide double-data-rate data bus one byte lane at a time. Each lane carries eight data wires and one inversion wire. For every transfer, the lane either sends its byte unchanged with the inversion wire low, or sends the complemented byte with the inversion wire high. It picks whichever choice changes no more than four of the nine wires relative to what the lane last drove.

The last driven nine-bit value of each lane is the reference for the next transfer. It is held in registers that load on every valid beat, so both beats of a two-beat burst update it. It is not cleared between commands and is kept unchanged while no data is valid. Only reset clears it, to all zeros.

A separate combinational receive path takes the encoded bytes with their inversion bits and restores the plain data. The receiving side needs no state for this. The encoder output is registered, with one cycle of latency.

Top module: `dbi_ac_codec`

## Requirements
- R1: While `rst` is high at a rising clock edge, after that edge `out_data`, `out_inv` and `out_valid` are all zero, and the reference of every lane becomes nine zero bits.
- R2: `out_valid` is high in the cycle after a rising edge at which `in_valid` was high, and low after an edge at which it was low; encoded outputs appear one cycle after their input.
- R3: For lane L (data bits 8L+7..8L, inversion bit `out_inv[L]`), if the candidate {inv=0, byte} differs from the lane's reference in at most 4 of 9 positions, the lane sends the byte unchanged with `out_inv[L]` = 0.
- R4: Otherwise (5 or more differing positions) the lane sends the bitwise complement of the byte with `out_inv[L]` = 1.
- R5: On every valid beat, each lane's 9 wires change in at most 4 positions compared with the previous cycle.
- R6: While `in_valid` is low, `out_data` and `out_inv` hold their values, and the next valid beat is compared against those held values, not against zeros.
- R7: The reference is updated on every valid beat, so back-to-back beats (both beats of a burst, or consecutive commands) are each encoded against the beat just before.
- R8: Lanes are independent: the choice made in one lane depends only on that lane's byte and reference.
- R9: The receive path outputs, for each lane L, `rx_data` byte L XOR eight copies of `rx_inv[L]`, combinationally.
- R10: Feeding `out_data`/`out_inv` into the receive path returns the `in_data` value of the beat that produced them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A data beat is present on `in_data` |
| in_data | input | LANES*8 | Plain data beat, byte lane L in bits 8L+7..8L |
| out_valid | output | 1 | Encoded beat present on the outputs |
| out_data | output | LANES*8 | Encoded data wires |
| out_inv | output | LANES | Inversion wire per lane |
| rx_data | input | LANES*8 | Encoded data to be restored |
| rx_inv | input | LANES | Inversion wires accompanying `rx_data` |
| rx_plain | output | LANES*8 | Restored plain data |

## Verification
The encoder is driven from a known reference with single-lane bytes placed at exactly four and exactly five wire changes. It is also driven from a reference whose inversion wire is already high, where the inversion wire's own change decides the outcome. Back-to-back beats separate a design that updates the reference on every beat from one that updates it per command. A beat sent after idle cycles shows whether the held value, rather than zero, is the reference. Pseudo-random multi-lane beats, each checked against a lane-by-lane reference model and decoded back, expose crossed lanes, wrong inversion polarity and a receive path that does not invert.

// File: rtl/dbi_ac_pkg.sv
package dbi_ac_pkg;

    localparam int BYTE_W     = 8;
    localparam int GRP_W      = BYTE_W + 1;
    localparam int MAX_TOGGLE = GRP_W / 2;
    localparam int CNT_W      = $clog2(GRP_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  inv;
        byte_t data;
    } lane_word_t;

    localparam lane_word_t LANE_ZERO = '{inv: 1'b0, data: '0};

    // number of wires that differ between two lane words
    function automatic logic [CNT_W-1:0] wire_changes(lane_word_t a, lane_word_t b);
        logic [GRP_W-1:0] diff;
        logic [CNT_W-1:0] n;
        diff = a ^ b;
        n = '0;
        for (int i = 0; i < GRP_W; i++) begin
            n = n + CNT_W'(diff[i]);
        end
        return n;
    endfunction

    function automatic lane_word_t complement_word(lane_word_t w);
        lane_word_t r;
        r.inv  = ~w.inv;
        r.data = ~w.data;
        return r;
    endfunction

endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc
    import dbi_ac_pkg::*;
(
    input  lane_word_t ref_word,
    input  byte_t      raw,
    output lane_word_t coded
);
    lane_word_t       plain_cand;
    logic [CNT_W-1:0] plain_cost;
    logic             pick_inv;

    always_comb begin
        plain_cand.inv  = 1'b0;
        plain_cand.data = raw;
        plain_cost      = wire_changes(plain_cand, ref_word);
        pick_inv        = (plain_cost > CNT_W'(MAX_TOGGLE));
        coded           = pick_inv ? complement_word(plain_cand) : plain_cand;
    end
endmodule

// File: rtl/dbi_lane_state.sv
module dbi_lane_state
    import dbi_ac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  lane_word_t next_word,
    output lane_word_t held_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_word <= LANE_ZERO;
        end else if (load) begin
            held_word <= next_word;
        end
    end
endmodule

// File: rtl/dbi_lane_dec.sv
module dbi_lane_dec
    import dbi_ac_pkg::*;
(
    input  lane_word_t wire_word,
    output byte_t      plain
);
    always_comb begin
        plain = wire_word.data ^ {BYTE_W{wire_word.inv}};
    end
endmodule

// File: rtl/dbi_ac_codec.sv
module dbi_ac_codec
    import dbi_ac_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [LANES*BYTE_W-1:0]  in_data,
    output logic                     out_valid,
    output logic [LANES*BYTE_W-1:0]  out_data,
    output logic [LANES-1:0]         out_inv,
    input  logic [LANES*BYTE_W-1:0]  rx_data,
    input  logic [LANES-1:0]         rx_inv,
    output logic [LANES*BYTE_W-1:0]  rx_plain
);
    localparam int DATA_W = LANES * BYTE_W;

    lane_word_t ref_q  [LANES];
    lane_word_t enc_d  [LANES];
    lane_word_t rx_w   [LANES];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dbi_lane_enc u_enc (
            .ref_word (ref_q[l]),
            .raw      (in_data[l*BYTE_W +: BYTE_W]),
            .coded    (enc_d[l])
        );

        dbi_lane_state u_state (
            .clk       (clk),
            .rst       (rst),
            .load      (in_valid),
            .next_word (enc_d[l]),
            .held_word (ref_q[l])
        );

        assign out_data[l*BYTE_W +: BYTE_W] = ref_q[l].data;
        assign out_inv[l]                   = ref_q[l].inv;

        assign rx_w[l].data = rx_data[l*BYTE_W +: BYTE_W];
        assign rx_w[l].inv  = rx_inv[l];

        dbi_lane_dec u_dec (
            .wire_word (rx_w[l]),
            .plain     (rx_plain[l*BYTE_W +: BYTE_W])
        );
    end

    if (DATA_W != LANES * GRP_W - LANES) begin : g_width_bad
        initial $error("lane width mismatch");
    end
endmodule

// File: rtl/dbi_ac_codec_chk.sv
module dbi_ac_codec_chk
    import dbi_ac_pkg::*;
#(
    parameter int LANES = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [LANES*BYTE_W-1:0] in_data,
    input logic                    out_valid,
    input logic [LANES*BYTE_W-1:0] out_data,
    input logic [LANES-1:0]        out_inv
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (out_data == '0 && out_inv == '0 && !out_valid));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(out_inv)));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // R5
        toggle_limit_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> ($countones({out_inv[l], out_data[l*BYTE_W +: BYTE_W]}
                ^ $past({out_inv[l], out_data[l*BYTE_W +: BYTE_W]})) <= MAX_TOGGLE));

        // R10
        roundtrip_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> ((out_data[l*BYTE_W +: BYTE_W] ^ {BYTE_W{out_inv[l]}})
                == $past(in_data[l*BYTE_W +: BYTE_W])));
    end
endmodule

bind dbi_ac_codec dbi_ac_codec_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_inv   (out_inv)
);

// File: tb/dbi_ac_codec_test.sv
module dbi_ac_codec_test;
    localparam int LANES = 16;
    localparam int DW    = LANES * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic [LANES-1:0] out_inv;
    logic [DW-1:0] rx_data = '0;
    logic [LANES-1:0] rx_inv = '0;
    logic [DW-1:0] rx_plain;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [DW-1:0]    m_data = '0;
    logic [LANES-1:0] m_inv  = '0;

    always #5 clk = ~clk;

    dbi_ac_codec #(.LANES(LANES)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_inv(out_inv),
        .rx_data(rx_data), .rx_inv(rx_inv), .rx_plain(rx_plain)
    );

    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] lane_model(logic [8:0] prev, logic [7:0] b);
        int n;
        n = $countones({1'b0, b} ^ prev);
        return (n > 4) ? {1'b1, ~b} : {1'b0, b};
    endfunction

    // one valid beat, outputs checked at the next falling edge
    task automatic beat(input logic [DW-1:0] d, input string req);
        logic [DW-1:0]    prev_d;
        logic [LANES-1:0] prev_i;
        int worst;
        prev_d = m_data;
        prev_i = m_inv;
        in_valid = 1'b1;
        in_data  = d;
        for (int l = 0; l < LANES; l++) begin
            logic [8:0] w;
            w = lane_model({m_inv[l], m_data[l*8 +: 8]}, d[l*8 +: 8]);
            m_inv[l] = w[8];
            m_data[l*8 +: 8] = w[7:0];
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R2 valid", DW'(out_valid), DW'(1));
        check(out_data === m_data, req, out_data, m_data);
        check(out_inv === m_inv, {req, " inv"}, DW'(out_inv), DW'(m_inv));
        worst = 0;
        for (int l = 0; l < LANES; l++) begin
            int n;
            n = $countones({out_inv[l], out_data[l*8 +: 8]} ^ {prev_i[l], prev_d[l*8 +: 8]});
            if (n > worst) worst = n;
        end
        check(worst <= 4, "R5 toggles", DW'(worst), DW'(4));
        rx_data = out_data;
        rx_inv  = out_inv;
        #1;
        check(rx_plain === d, "R10 roundtrip", rx_plain, d);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        m_data = '0;
        m_inv  = '0;
        check(out_data === '0 && out_inv === '0, "R1 data/inv", {out_inv, out_data[DW-LANES-1:0]}, '0);
        check(out_valid === 1'b0, "R1 valid", DW'(out_valid), '0);
        rst = 1'b0;
    endtask

    task automatic t_boundary();
        do_reset();
        beat(DW'(8'h0F), "R3 four changes sent true");
        check(out_data[7:0] === 8'h0F && out_inv[0] === 1'b0, "R3 lane0",
              DW'({out_inv[0], out_data[7:0]}), DW'(9'h00F));
        beat(DW'(8'hF0), "R4 eight changes inverted");
        check(out_data[7:0] === 8'h0F && out_inv[0] === 1'b1, "R4 lane0",
              DW'({out_inv[0], out_data[7:0]}), DW'(9'h10F));
        // reference {1,0F}: true candidate costs 1 wire
        beat(DW'(8'h0F), "R3 inv wire counted");
        check(out_data[7:0] === 8'h0F && out_inv[0] === 1'b0, "R3 lane0 back",
              DW'({out_inv[0], out_data[7:0]}), DW'(9'h00F));
        do_reset();
        beat(DW'(8'h1F), "R4 five changes");
        check(out_data[7:0] === 8'hE0 && out_inv[0] === 1'b1, "R4 lane0 five",
              DW'({out_inv[0], out_data[7:0]}), DW'(9'h1E0));
        // reference {1,E0}: 0xE0 true costs 1 wire, inverted costs 8
        beat(DW'(8'hE0), "R3 from inverted ref");
    endtask

    task automatic t_idle();
        logic [DW-1:0]    hd;
        logic [LANES-1:0] hi;
        beat({LANES{8'hA5}}, "R6 pre-idle");
        hd = out_data;
        hi = out_inv;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R2 idle valid", DW'(out_valid), '0);
        check(out_data === hd && out_inv === hi, "R6 hold", out_data, hd);
        beat({LANES{8'h5A}}, "R6 held reference");
    endtask

    task automatic t_burst();
        for (int k = 0; k < 6; k++) begin
            beat({LANES{8'hFF}} ^ DW'(k), "R7 burst beat A");
            beat({LANES{8'h00}} | DW'(k * 3), "R7 burst beat B");
        end
    endtask

    task automatic t_lanes();
        for (int k = 0; k < 40; k++) begin
            logic [DW-1:0] d;
            for (int w = 0; w < DW / 32; w++) d[w*32 +: 32] = $urandom;
            beat(d, "R8 per-lane");
            if (k % 7 == 0) @(negedge clk);
        end
    endtask

    task automatic t_decoder();
        for (int k = 0; k < 8; k++) begin
            logic [DW-1:0] exp;
            for (int w = 0; w < DW / 32; w++) rx_data[w*32 +: 32] = $urandom;
            rx_inv = LANES'($urandom);
            #1;
            for (int l = 0; l < LANES; l++) exp[l*8 +: 8] = rx_data[l*8 +: 8] ^ {8{rx_inv[l]}};
            check(rx_plain === exp, "R9 decoder", rx_plain, exp);
        end
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_boundary();
        t_idle();
        t_burst();
        t_lanes();
        t_decoder();
        do_reset();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule